// File: doc/BRIEF.md
# Free-Running Timer with Overflow Flag

This block is an 8-bit timer that only ever counts upward and is never cleared by hardware. It advances by one on each timer tick, and a 3-bit select input picks where that tick comes from. The counter can be stopped. It can follow one of five internal enable taps, which a divider chain outside this block supplies. It can also follow the falling or the rising edges of an external pin, which is first synchronized and then passed through an edge detector. After 0xFF the next tick takes the count to 0x00.

On that wrapping tick a sticky overflow flag is set. It behaves like a ninth counter bit that the counter can set but never clear. Two things clear it: an interrupt acknowledge, or a bus write of one to the flag. The interrupt request output is high while the flag and its enable are both set. The bus can load the counter at any time, whether the timer is running or stopped, and a load takes priority over a tick in the same cycle.

Top module: `ovf_timer8`

## Requirements
- R1: Each timer tick without a load raises the count by exactly one, and a tick at 0xFF gives 0x00. The new value is visible after the clock edge at which the tick is sampled.
- R2: With select 0 the count holds its value whatever the tap and pin inputs do.
- R3: Select values 1 to 5 take the tick from tap input bit (select − 1). Tap bits that are not selected have no effect.
- R4: Select 6 counts falling pin edges and select 7 counts rising pin edges, one tick per edge. A pin change set up before clock edge k changes the count after edge k+2 and not before.
- R5: A load sets the count to the load data after the next edge, even when a tick occurs in that cycle and even when the timer is stopped.
- R6: The overflow flag is set at the same edge where a tick takes the count from 0xFF to 0x00. A load of 0x00 does not set it.
- R7: The flag stays set until an acknowledge pulse or a write-one-to-clear pulse clears it. If a set and a clear fall in the same cycle, the flag ends up set.
- R8: The interrupt request equals the flag ANDed with the interrupt enable input.
- R9: After a synchronous active-low reset the count is 0x00, the flag is 0 and the pin synchronizer holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel_i | input | 3 | Tick source: 0 stop, 1-5 tap, 6 pin falling, 7 pin rising |
| tap_en_i | input | 5 | Internal prescaled tick enables |
| ext_pin_i | input | 1 | Asynchronous external count pin |
| cnt_wr_i | input | 1 | Bus load strobe for the counter |
| cnt_wdata_i | input | 8 | Bus load value |
| flag_w1c_i | input | 1 | Bus write of one to the overflow flag |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| irq_en_i | input | 1 | Overflow interrupt enable |
| cnt_o | output | 8 | Current count |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the tap, load, clear and acknowledge inputs are synchronous to the clock and are held low during reset. They also assume that the external pin is low while reset is active, so the synchronizer starts from a known level. The stimulus changes every input on the falling clock edge and holds the pin low through reset. Pin levels are held for random runs of cycles, sometimes for a single cycle, to exercise the synchronizer latency. Loads, clears and acknowledges are placed deliberately on wrapping ticks to test the collision rules.

// File: rtl/ovf_timer_pkg.sv
// Shared constants for the overflow timer: tick-source select encoding.
package ovf_timer_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_STOP     = 3'd0,
        SEL_EXT_FALL = 3'd6,
        SEL_EXT_RISE = 3'd7
    } tick_sel_e;
endpackage

// File: rtl/ovf_pin_edge.sv
// Synchronizes an asynchronous pin through SYNC_STAGES flops and flags
// single-cycle rise and fall pulses. Assumes the pin is low during reset.
module ovf_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift the pin into the synchronizer chain and keep the last settled level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Decode one pulse per settled transition.
    always_comb begin
        rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;
        fall_o = ~sync_q[SYNC_STAGES-1] & prev_q;
    end

    // R4: a detected edge produces exactly one tick, never two in a row.
    assert_one_rise_per_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
    assert_one_fall_per_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/ovf_tick_mux.sv
// Chooses the timer tick from the select code: stop, one of NTAPS internal
// enables, or a pin edge. Purely combinational.
module ovf_tick_mux
    import ovf_timer_pkg::*;
#(
    parameter int NTAPS = 5
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic [NTAPS-1:0] taps_i,
    input  logic             rise_i,
    input  logic             fall_i,
    output logic             tick_o
);
    logic [NTAPS-1:0] tap_hit;

    // One match line per internal tap, code i+1 selects tap i.
    genvar gi;
    generate
        for (gi = 0; gi < NTAPS; gi++) begin : g_tap
            assign tap_hit[gi] = (sel_i == SEL_W'(gi + 1)) & taps_i[gi];
        end
    endgenerate

    // Merge internal taps with the pin edge sources.
    always_comb begin
        tick_o = |tap_hit;
        if (sel_i == SEL_EXT_FALL) tick_o = fall_i;
        if (sel_i == SEL_EXT_RISE) tick_o = rise_i;
    end

    // R2: a stopped timer never produces a tick.
    always_comb begin
        assert_stop_no_tick_R2: assert (!(sel_i == SEL_STOP && tick_o === 1'b1));
    end
endmodule

// File: rtl/ovf_count_core.sv
// Up-counter with load priority and sticky overflow flag.
// Assumes tick, load and clear inputs are synchronous to clk.
module ovf_count_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             ack_i,
    input  logic             w1c_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic wrap;

    // A counted wrap from the top value is the only flag set condition.
    always_comb wrap = tick_i & ~wr_i & (cnt_o == CNT_MAX);

    // Load wins over counting.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_o <= '0;
        else if (wr_i)   cnt_o <= wdata_i;
        else if (tick_i) cnt_o <= cnt_o + 1'b1;
    end

    // Sticky flag: set wins over acknowledge and write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)              flag_o <= 1'b0;
        else if (wrap)           flag_o <= 1'b1;
        else if (ack_i || w1c_i) flag_o <= 1'b0;
    end

    assert_load_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> cnt_o == $past(wdata_i));
    assert_tick_increments_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_i) |=> cnt_o == $past(cnt_o) + 1'b1);
    assert_wrap_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_i && cnt_o == CNT_MAX) |=> (flag_o && cnt_o == '0));
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !ack_i && !w1c_i) |=> flag_o);
    assert_flag_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_i || w1c_i) && !(tick_i && !wr_i && cnt_o == CNT_MAX)) |=> !flag_o);
endmodule

// File: rtl/ovf_timer8.sv
// Top of the free-running overflow timer: pin edge detector, tick source
// mux and counter core. Assumes synchronous bus strobes and a low pin in reset.
module ovf_timer8
    import ovf_timer_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int NTAPS       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] clk_sel_i,
    input  logic [NTAPS-1:0] tap_en_i,
    input  logic             ext_pin_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    input  logic             flag_w1c_i,
    input  logic             irq_ack_i,
    input  logic             irq_en_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_flag_o,
    output logic             irq_o
);
    logic pin_rise, pin_fall, tick;

    ovf_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin_i),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    ovf_tick_mux #(.NTAPS(NTAPS)) u_mux (
        .sel_i  (clk_sel_i),
        .taps_i (tap_en_i),
        .rise_i (pin_rise),
        .fall_i (pin_fall),
        .tick_o (tick)
    );

    ovf_count_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .wr_i    (cnt_wr_i),
        .wdata_i (cnt_wdata_i),
        .ack_i   (irq_ack_i),
        .w1c_i   (flag_w1c_i),
        .cnt_o   (cnt_o),
        .flag_o  (ovf_flag_o)
    );

    // Interrupt request gated by its enable.
    always_comb irq_o = ovf_flag_o & irq_en_i;

    assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel_i == SEL_STOP && !cnt_wr_i) |=> $stable(cnt_o));
    assert_irq_follows_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_i && $rose(ovf_flag_o)) |-> irq_o);
endmodule

// File: tb/tb_ovf_timer8.sv
module tb_ovf_timer8;
    localparam int CLK_PERIOD = 10;
    localparam int QTR = CLK_PERIOD / 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel = '0;
    logic [4:0] taps = '0;
    logic       pin = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic       w1c = 1'b0;
    logic       ack = 1'b0;
    logic       ie = 1'b0;
    logic [7:0] cnt;
    logic       flag, irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference model state
    int m_cnt = 0;
    int m_flag = 0;
    int pin_q[$] = '{0, 0, 0};

    always #(CLK_PERIOD/2) clk = ~clk;

    ovf_timer8 dut (
        .clk(clk), .rst_n(rst_n), .clk_sel_i(sel), .tap_en_i(taps),
        .ext_pin_i(pin), .cnt_wr_i(wr), .cnt_wdata_i(wdata),
        .flag_w1c_i(w1c), .irq_ack_i(irq_ack_i_w), .irq_en_i(ie),
        .cnt_o(cnt), .ovf_flag_o(flag), .irq_o(irq)
    );
    wire irq_ack_i_w = ack;

    // Behavioural model: pin history queue, tick choice, count and flag update.
    always @(posedge clk) begin
        int tk, set_now, s2, s3;
        if (!rst_n) begin
            m_cnt = 0;
            m_flag = 0;
            pin_q = '{0, 0, 0};
        end else begin
            s2 = pin_q[1];
            s3 = pin_q[2];
            tk = 0;
            if (sel >= 1 && sel <= 5) tk = taps[sel - 1];
            if (sel == 6) tk = (s2 == 0 && s3 == 1);
            if (sel == 7) tk = (s2 == 1 && s3 == 0);
            set_now = (tk != 0) && !wr && (m_cnt == 255);
            if (wr) m_cnt = wdata;
            else if (tk != 0) m_cnt = (m_cnt + 1) % 256;
            if (set_now) m_flag = 1;
            else if (ack || w1c) m_flag = 0;
            pin_q.push_front(int'(pin));
            void'(pin_q.pop_back());
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model, a quarter period after the falling edge.
    always @(negedge clk) begin
        #(QTR);
        if (rst_n && !done) begin
            check(cnt == m_cnt[7:0], "R1 count", cnt, m_cnt);
            check(flag == m_flag[0], "R6 flag", flag, m_flag);
            check(irq == (m_flag[0] & ie), "R8 irq", irq, m_flag & ie);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [7:0] v);
        wr = 1'b1; wdata = v; cyc(1); wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] hold;
        cyc(3);
        #1;
        check(cnt == 8'h00 && flag == 1'b0, "R9 reset", {flag, cnt}, 0);
        rst_n = 1'b1;

        // R1/R6: count through a wrap from tap 0.
        sel = 3'd1; taps = 5'b00001;
        load(8'hFC);
        cyc(3);
        #1 check(cnt == 8'hFF && flag == 1'b0, "R1 before wrap", cnt, 8'hFF);
        cyc(1);
        #1 check(cnt == 8'h00 && flag == 1'b1, "R6 flag at wrap", {flag, cnt}, 9'h100);
        ie = 1'b1; #1 check(irq == 1'b1, "R8 irq on", irq, 1);
        ie = 1'b0; #1 check(irq == 1'b0, "R8 irq masked", irq, 0);
        ie = 1'b1;
        cyc(5);
        #1 check(flag == 1'b1, "R7 sticky", flag, 1);
        ack = 1'b1; cyc(1); ack = 1'b0;
        #1 check(flag == 1'b0, "R7 ack clears", flag, 0);

        // R7: set wins over a simultaneous write-one-to-clear.
        taps = '0; load(8'hFF);
        taps = 5'b00001; w1c = 1'b1; cyc(1); w1c = 1'b0; taps = '0;
        #1 check(flag == 1'b1 && cnt == 8'h00, "R7 set wins", flag, 1);
        w1c = 1'b1; cyc(1); w1c = 1'b0;
        #1 check(flag == 1'b0, "R7 w1c clears", flag, 0);

        // R5/R6: load collides with tick; loading zero does not set the flag.
        load(8'hFF);
        taps = 5'b00001; wr = 1'b1; wdata = 8'h00; cyc(1); wr = 1'b0;
        #1 check(cnt == 8'h00 && flag == 1'b0, "R5 load beats tick", {flag, cnt}, 0);

        // R2: stopped, taps and pin toggling, load still works.
        sel = 3'd0; load(8'h42);
        for (int i = 0; i < 20; i++) begin
            taps = 5'(i); pin = i[1]; cyc(1);
        end
        #1 check(cnt == 8'h42, "R2 stopped hold", cnt, 8'h42);
        load(8'h17);
        #1 check(cnt == 8'h17, "R5 load while stopped", cnt, 8'h17);
        pin = 1'b0; cyc(4);

        // R3: only the selected tap counts.
        sel = 3'd4; taps = 5'b10111; load(8'h00);
        cyc(10);
        #1 check(cnt == 8'h00, "R3 unselected taps", cnt, 0);
        taps = 5'b01000; cyc(10);
        #1 check(cnt == 8'h0A, "R3 tap 3", cnt, 8'h0A);
        for (int s = 1; s <= 5; s++) begin
            sel = 3'(s);
            for (int i = 0; i < 40; i++) begin taps = 5'($urandom); cyc(1); end
        end

        // R4: pin latency, rising edges then falling edges.
        sel = 3'd7; taps = '0; pin = 1'b0; cyc(4); load(8'h10);
        pin = 1'b1; hold = cnt;
        cyc(2);
        #1 check(cnt == hold, "R4 no early count", cnt, hold);
        cyc(1);
        #1 check(cnt == hold + 8'd1, "R4 latency", cnt, hold + 8'd1);
        sel = 3'd6;
        for (int i = 0; i < 300; i++) begin pin = ~pin; cyc(1 + ($urandom % 3)); end
        sel = 3'd7;
        for (int i = 0; i < 300; i++) begin pin = ~pin; cyc(1 + ($urandom % 3)); end

        // Mixed random traffic against the model.
        for (int i = 0; i < 4000; i++) begin
            sel   = 3'($urandom);
            taps  = 5'($urandom);
            if ($urandom % 3 == 0) pin = ~pin;
            wr    = ($urandom % 23 == 0);
            wdata = ($urandom % 2) ? 8'hFE : 8'($urandom);
            ack   = ($urandom % 17 == 0);
            w1c   = ($urandom % 19 == 0);
            ie    = ($urandom % 4 != 0);
            cyc(1);
        end
        wr = 0; ack = 0; w1c = 0;
        cyc(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule